// File: doc/BRIEF.md
# Translation Permission and Fault Classifier

This block makes the final decision for a single memory access in a segmented, hash-paged address translator. It does not search tables itself. The neighbouring block-range matcher and page walker deliver their results, and the currently selected segment word arrives alongside them. From these the classifier picks the one rule that governs the access. It then reports either a granted real address with a read/write/execute permission set, or a fault. A fault carries its type (instruction, data or alignment), a 32-bit syndrome word and, for data-side faults, the faulting address.

Every request is sampled on a clock edge while `req_valid` is high. All outputs are registered, and the verdict appears with a one-cycle `rsp_valid` pulse on the next edge. Requests may arrive back to back. The rules are tried in a fixed order, and the first one that applies decides the result:

1. translation switched off for the access side;
2. a block-range hit;
3. a direct-store segment;
4. a fetch from a no-execute segment;
5. a missing page entry;
6. the page permission check.

Top module: `xlate_verdict`

## Requirements
- R1: With translation off for the access side (`xlat_on_inst` for fetches, kind 2; `xlat_on_data` for reads, kind 0, and writes, kind 1), the access is granted with `rsp_real`=1, real address equal to the effective address and permission 3'b111 (bit0 read, bit1 write, bit2 execute).
- R2: When translation is on and `blk_hit` is set, the block result takes priority over every segment and page input. If `blk_perm` holds the needed bit, the grant uses `blk_raddr` and `blk_perm`. Otherwise the fault codes of R6 apply.
- R3: Segment word bit 31 marks a direct-store segment, bit 30 is the supervisor key, bit 29 is the user key and bit 28 is no-execute. The key is bit 29 when `user_mode`=1 and bit 30 otherwise. With key 0, PP values 0, 1 and 2 give read/write and PP 3 gives read only. With key 1, PP 0 gives nothing, PP 1 and PP 3 give read only, and PP 2 gives read/write. Execute is added when bit 28 is clear. A granted page access uses the real page number from `pg_raddr` above bit 12 and the low 12 bits of the effective address.
- R4: A fetch into a direct-store segment that is not the forced-memory case, or a fetch into a page segment with bit 28 set, gives an instruction fault (type 1) with code 0x10000000. This takes priority over the page lookup.
- R5: A missing page entry gives code 0x40000000 as an instruction fault for a fetch. For a data access it gives a data fault (type 2) with code 0x42000000 for a write or 0x40000000 for a read.
- R6: A permission shortfall gives code 0x08000000 as an instruction fault for a fetch. For a data access it gives a data fault with code 0x0A000000 for a write or 0x08000000 for a read.
- R7: In a direct-store segment whose bus ID (segment bits 28:20) equals 0x07F, any access kind is granted with permission 3'b111. The real address is segment bits 3:0 above effective-address bits 27:0.
- R8: For other direct-store data accesses, `ds_class` decides the result:
  - 1, float: alignment fault (type 3) with code 0;
  - 2, reservation: data fault with code 0x06000000 for a write or 0x04000000 for a read;
  - 3, cache operation: granted with the effective address and only the requested bit;
  - 4, external control: data fault with code 0x06100000 for a write or 0x04100000 for a read.
- R9: A direct-store integer access (`ds_class` 0) is granted with the effective address and only the requested bit when it is a read with key 0 or a write with key 1. Otherwise it raises the R6 data codes.
- R10: Access kind 3 is flagged with `rsp_illegal`=1, as is an unnamed `ds_class` (5 to 7) once the direct-store class is consulted. Neither outcome grants or faults.
- R11: Each request with `req_valid` high produces exactly one `rsp_valid` pulse on the following edge, and none without a request. After reset, `rsp_valid` is 0. `rsp_far` carries the effective address on data and alignment faults and is 0 otherwise.
- R12: Every response has exactly one of granted, faulted (`rsp_ftype`≠0) or illegal. Granted and illegal responses carry code 0, and any response that is not a grant carries real address 0 and permission 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 illegal |
| req_ea | input | AW | Effective address |
| xlat_on_inst | input | 1 | Instruction-side translation enable |
| xlat_on_data | input | 1 | Data-side translation enable |
| user_mode | input | 1 | Problem (user) state |
| seg_word | input | 32 | Segment word selected by the top address bits |
| blk_hit | input | 1 | Block-range matcher hit |
| blk_raddr | input | AW | Real address from the block matcher |
| blk_perm | input | 3 | Block permissions (bit0 R, bit1 W, bit2 X) |
| pg_found | input | 1 | Page walker found an entry |
| pg_raddr | input | AW | Real page address from the walker |
| pg_pp | input | 2 | Page protection field |
| ds_class | input | 3 | Direct-store access class (0 int, 1 float, 2 reservation, 3 cache, 4 external) |
| rsp_valid | output | 1 | One-cycle verdict strobe |
| rsp_ok | output | 1 | Access granted |
| rsp_real | output | 1 | Granted through untranslated mode |
| rsp_illegal | output | 1 | Request could not be classified |
| rsp_ftype | output | 2 | 0 none, 1 instruction, 2 data, 3 alignment |
| rsp_code | output | 32 | Error or syndrome word |
| rsp_raddr | output | AW | Real address of a grant |
| rsp_far | output | AW | Faulting address for data-side faults |
| rsp_perm | output | 3 | Granted permissions |

## Verification
A wrong decision in the priority chain becomes visible one edge after the request. It shows up as the wrong fault type or syndrome, or as a grant where a fault belongs. An address-select error shows as a real address taken from the wrong source, for example the block result leaking into a direct-store access. Because the response registers only load when a request arrives, a stale or stuck field from an earlier request is seen on the very next pulse. Comparing every cycle against the reference also catches a missing or doubled `rsp_valid` on the edge it occurs.

// File: rtl/xv_pkg.sv
package xv_pkg;

  localparam int SEG_W = 32;
  localparam int CODE_W = 32;
  localparam int SEG_DS_BIT = 31;
  localparam int SEG_KS_BIT = 30;
  localparam int SEG_KU_BIT = 29;
  localparam int SEG_NX_BIT = 28;

  typedef enum logic [1:0] {
    K_READ  = 2'd0,
    K_WRITE = 2'd1,
    K_FETCH = 2'd2,
    K_BAD   = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    F_NONE  = 2'd0,
    F_INST  = 2'd1,
    F_DATA  = 2'd2,
    F_ALIGN = 2'd3
  } ftype_e;

  typedef enum logic [2:0] {
    A_ZERO   = 3'd0,
    A_EA     = 3'd1,
    A_BLOCK  = 3'd2,
    A_PAGE   = 3'd3,
    A_FORCED = 3'd4
  } asel_e;

  localparam logic [2:0] C_INT   = 3'd0;
  localparam logic [2:0] C_FLOAT = 3'd1;
  localparam logic [2:0] C_RESV  = 3'd2;
  localparam logic [2:0] C_CACHE = 3'd3;
  localparam logic [2:0] C_EXT   = 3'd4;

  localparam logic [CODE_W-1:0] SYN_NOEXEC  = 32'h1000_0000;
  localparam logic [CODE_W-1:0] SYN_MISS    = 32'h4000_0000;
  localparam logic [CODE_W-1:0] SYN_MISS_ST = 32'h4200_0000;
  localparam logic [CODE_W-1:0] SYN_PROT    = 32'h0800_0000;
  localparam logic [CODE_W-1:0] SYN_PROT_ST = 32'h0A00_0000;
  localparam logic [CODE_W-1:0] SYN_RESV    = 32'h0400_0000;
  localparam logic [CODE_W-1:0] SYN_RESV_ST = 32'h0600_0000;
  localparam logic [CODE_W-1:0] SYN_EXT     = 32'h0410_0000;
  localparam logic [CODE_W-1:0] SYN_EXT_ST  = 32'h0610_0000;
  localparam logic [CODE_W-1:0] SYN_ALIGN   = 32'h0000_0000;

  typedef struct packed {
    logic              ok;
    logic              real_m;
    logic              bad;
    ftype_e            ftype;
    logic [CODE_W-1:0] code;
    logic [2:0]        perm;
    logic              far_en;
    asel_e             asel;
  } verdict_t;

  // one-hot permission bit needed by an access kind
  function automatic logic [2:0] need_of(input logic [1:0] kind);
    logic [2:0] m;
    case (kind)
      K_READ:  m = 3'b001;
      K_WRITE: m = 3'b010;
      K_FETCH: m = 3'b100;
      default: m = 3'b000;
    endcase
    return m;
  endfunction

  function automatic verdict_t v_grant(input logic [2:0] p, input asel_e a);
    verdict_t v;
    v        = '0;
    v.ok     = 1'b1;
    v.perm   = p;
    v.asel   = a;
    return v;
  endfunction

  function automatic verdict_t v_fault(input ftype_e t, input logic [CODE_W-1:0] c,
                                       input logic far);
    verdict_t v;
    v        = '0;
    v.ftype  = t;
    v.code   = c;
    v.far_en = far;
    return v;
  endfunction

  function automatic verdict_t v_bad();
    verdict_t v;
    v     = '0;
    v.bad = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/xv_key_table.sv
// Key-by-protection-field table: turns the active key, the page PP field
// and the segment no-execute bit into a read/write/execute set.
module xv_key_table (
  input  logic       key,
  input  logic [1:0] pp,
  input  logic       nx,
  output logic [2:0] perm
);
  logic rd;
  logic wr;

  always_comb begin
    rd = 1'b1;
    wr = 1'b0;
    if (!key) begin
      wr = (pp != 2'd3);
    end else begin
      case (pp)
        2'd0:    rd = 1'b0;
        2'd2:    wr = 1'b1;
        default: ;
      endcase
    end
    perm = {~nx, wr, rd};
  end
endmodule

// File: rtl/xv_prot_check.sv
// Compares the permission a source offers with the one the access needs
// and forms either a grant or a protection fault.
module xv_prot_check
  import xv_pkg::*;
(
  input  logic [1:0] kind,
  input  logic [2:0] have,
  input  asel_e      asel,
  output verdict_t   verdict
);
  logic [2:0] need;
  logic       short;

  always_comb begin
    need  = need_of(kind);
    short = |(need & ~have);
    if (!short) begin
      verdict = v_grant(have, asel);
    end else if (kind == K_FETCH) begin
      verdict = v_fault(F_INST, SYN_PROT, 1'b0);
    end else if (kind == K_WRITE) begin
      verdict = v_fault(F_DATA, SYN_PROT_ST, 1'b1);
    end else begin
      verdict = v_fault(F_DATA, SYN_PROT, 1'b1);
    end
  end
endmodule

// File: rtl/xv_dstore.sv
// Outcome of an access that lands in a direct-store segment.
module xv_dstore
  import xv_pkg::*;
#(
  parameter int          BUS_ID_W  = 9,
  parameter logic [8:0]  FORCED_ID = 9'h07F
) (
  input  logic [1:0]          kind,
  input  logic                key,
  input  logic [BUS_ID_W-1:0] bus_id,
  input  logic [2:0]          cls,
  output verdict_t            verdict
);
  logic       is_wr;
  logic [2:0] need;
  logic       int_ok;

  always_comb begin
    is_wr  = (kind == K_WRITE);
    need   = need_of(kind);
    int_ok = (is_wr && key) || ((kind == K_READ) && !key);
    if (bus_id == FORCED_ID[BUS_ID_W-1:0]) begin
      verdict = v_grant(3'b111, A_FORCED);
    end else if (kind == K_FETCH) begin
      verdict = v_fault(F_INST, SYN_NOEXEC, 1'b0);
    end else begin
      case (cls)
        C_INT: begin
          if (int_ok) verdict = v_grant(need, A_EA);
          else        verdict = v_fault(F_DATA, is_wr ? SYN_PROT_ST : SYN_PROT, 1'b1);
        end
        C_FLOAT: verdict = v_fault(F_ALIGN, SYN_ALIGN, 1'b1);
        C_RESV:  verdict = v_fault(F_DATA, is_wr ? SYN_RESV_ST : SYN_RESV, 1'b1);
        C_CACHE: verdict = v_grant(need, A_EA);
        C_EXT:   verdict = v_fault(F_DATA, is_wr ? SYN_EXT_ST : SYN_EXT, 1'b1);
        default: verdict = v_bad();
      endcase
    end
  end
endmodule

// File: rtl/xlate_verdict.sv
module xlate_verdict
  import xv_pkg::*;
#(
  parameter int         AW        = 32,
  parameter int         PAGE_BITS = 12,
  parameter int         BUS_ID_LO = 20,
  parameter int         BUS_ID_W  = 9,
  parameter int         FWD_HI_W  = 4,
  parameter logic [8:0] FORCED_ID = 9'h07F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [AW-1:0]     req_ea,
  input  logic              xlat_on_inst,
  input  logic              xlat_on_data,
  input  logic              user_mode,
  input  logic [31:0]       seg_word,
  input  logic              blk_hit,
  input  logic [AW-1:0]     blk_raddr,
  input  logic [2:0]        blk_perm,
  input  logic              pg_found,
  input  logic [AW-1:0]     pg_raddr,
  input  logic [1:0]        pg_pp,
  input  logic [2:0]        ds_class,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic              rsp_real,
  output logic              rsp_illegal,
  output logic [1:0]        rsp_ftype,
  output logic [31:0]       rsp_code,
  output logic [AW-1:0]     rsp_raddr,
  output logic [AW-1:0]     rsp_far,
  output logic [2:0]        rsp_perm
);
  localparam int FWD_LO_W = AW - FWD_HI_W;
  localparam int BUS_ID_HI = BUS_ID_LO + BUS_ID_W - 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  // request decode
  logic       is_fetch;
  logic       is_write;
  logic       kind_bad;
  logic       xl_on;
  logic       key;
  logic [2:0] pg_perm;
  verdict_t   blk_v;
  verdict_t   pg_v;
  verdict_t   ds_v;
  verdict_t   nxt;
  logic [AW-1:0] raddr_d;
  logic [AW-1:0] far_d;
  logic          unused_bits;

  assign is_fetch = (req_kind == K_FETCH);
  assign is_write = (req_kind == K_WRITE);
  assign kind_bad = (req_kind == K_BAD);
  assign xl_on    = is_fetch ? xlat_on_inst : xlat_on_data;
  assign key      = user_mode ? seg_word[SEG_KU_BIT] : seg_word[SEG_KS_BIT];
  assign unused_bits = ^{seg_word[BUS_ID_LO-1:FWD_HI_W], pg_raddr[PAGE_BITS-1:0]};

  xv_key_table u_key_table (
    .key  (key),
    .pp   (pg_pp),
    .nx   (seg_word[SEG_NX_BIT]),
    .perm (pg_perm)
  );

  xv_prot_check u_blk_check (
    .kind    (req_kind),
    .have    (blk_perm),
    .asel    (A_BLOCK),
    .verdict (blk_v)
  );

  xv_prot_check u_pg_check (
    .kind    (req_kind),
    .have    (pg_perm),
    .asel    (A_PAGE),
    .verdict (pg_v)
  );

  xv_dstore #(
    .BUS_ID_W  (BUS_ID_W),
    .FORCED_ID (FORCED_ID)
  ) u_dstore (
    .kind    (req_kind),
    .key     (key),
    .bus_id  (seg_word[BUS_ID_HI:BUS_ID_LO]),
    .cls     (ds_class),
    .verdict (ds_v)
  );

  // priority chain: first rule that applies decides
  always_comb begin
    if (kind_bad) begin
      nxt = v_bad();
    end else if (!xl_on) begin
      nxt        = v_grant(3'b111, A_EA);
      nxt.real_m = 1'b1;
    end else if (blk_hit) begin
      nxt = blk_v;
    end else if (seg_word[SEG_DS_BIT]) begin
      nxt = ds_v;
    end else if (is_fetch && seg_word[SEG_NX_BIT]) begin
      nxt = v_fault(F_INST, SYN_NOEXEC, 1'b0);
    end else if (!pg_found) begin
      if (is_fetch)      nxt = v_fault(F_INST, SYN_MISS, 1'b0);
      else if (is_write) nxt = v_fault(F_DATA, SYN_MISS_ST, 1'b1);
      else               nxt = v_fault(F_DATA, SYN_MISS, 1'b1);
    end else begin
      nxt = pg_v;
    end
  end

  always_comb begin
    case (nxt.asel)
      A_EA:     raddr_d = req_ea;
      A_BLOCK:  raddr_d = blk_raddr;
      A_PAGE:   raddr_d = {pg_raddr[AW-1:PAGE_BITS], req_ea[PAGE_BITS-1:0]};
      A_FORCED: raddr_d = {seg_word[FWD_HI_W-1:0], req_ea[FWD_LO_W-1:0]};
      default:  raddr_d = '0;
    endcase
    far_d = nxt.far_en ? req_ea : '0;
  end

  // response registers, loaded only when a request is present
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rsp_valid   <= 1'b0;
      rsp_ok      <= 1'b0;
      rsp_real    <= 1'b0;
      rsp_illegal <= 1'b0;
      rsp_ftype   <= 2'd0;
      rsp_code    <= '0;
      rsp_raddr   <= '0;
      rsp_far     <= '0;
      rsp_perm    <= 3'd0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_ok      <= nxt.ok;
        rsp_real    <= nxt.real_m;
        rsp_illegal <= nxt.bad;
        rsp_ftype   <= nxt.ftype;
        rsp_code    <= nxt.code;
        rsp_raddr   <= raddr_d;
        rsp_far     <= far_d;
        rsp_perm    <= nxt.perm;
      end
    end
  end

endmodule

// File: rtl/xlate_verdict_chk.sv
module xlate_verdict_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [1:0]    req_kind,
  input logic [AW-1:0] req_ea,
  input logic          xlat_on_inst,
  input logic [31:0]   seg_word,
  input logic          blk_hit,
  input logic          rsp_valid,
  input logic          rsp_ok,
  input logic          rsp_real,
  input logic          rsp_illegal,
  input logic [1:0]    rsp_ftype,
  input logic [31:0]   rsp_code,
  input logic [AW-1:0] rsp_raddr,
  input logic [AW-1:0] rsp_far,
  input logic [2:0]    rsp_perm
);

  // R11: a response only follows a request
  a_r11_valid_from_req: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));

  // R12: exactly one outcome per response
  a_r12_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_ok, rsp_ftype != 2'd0, rsp_illegal}) == 1));

  // R12: granted responses carry no code
  a_r12_code_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ok) |-> (rsp_code == 32'd0));

  // R1: untranslated grant keeps the address and gives all rights
  a_r1_real_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_real) |->
      (rsp_ok && rsp_perm == 3'b111 && rsp_raddr == $past(req_ea)));

  // R4: fetch into a no-execute page segment
  a_r4_nx_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_kind == 2'd2 && xlat_on_inst && !blk_hit &&
                        !seg_word[31] && seg_word[28])) |->
      (rsp_ftype == 2'd1 && rsp_code == 32'h1000_0000));

  // R11: faulting address only on data-side faults
  a_r11_far_data_only: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_ftype == 2'd0 || rsp_ftype == 2'd1)) |-> (rsp_far == '0));

  // R10: kind 3 is always flagged
  a_r10_bad_kind: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_kind == 2'd3)) |-> rsp_illegal);

endmodule

bind xlate_verdict xlate_verdict_chk #(.AW(AW)) u_chk (.*);

// File: tb/xlate_verdict_bench.sv
module xlate_verdict_bench;

  typedef struct packed {
    logic        ok;
    logic        rl;
    logic        bad;
    logic [1:0]  ft;
    logic [31:0] code;
    logic [31:0] raddr;
    logic [31:0] far;
    logic [2:0]  perm;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [31:0] req_ea;
  logic        xlat_on_inst;
  logic        xlat_on_data;
  logic        user_mode;
  logic [31:0] seg_word;
  logic        blk_hit;
  logic [31:0] blk_raddr;
  logic [2:0]  blk_perm;
  logic        pg_found;
  logic [31:0] pg_raddr;
  logic [1:0]  pg_pp;
  logic [2:0]  ds_class;
  logic        rsp_valid;
  logic        rsp_ok;
  logic        rsp_real;
  logic        rsp_illegal;
  logic [1:0]  rsp_ftype;
  logic [31:0] rsp_code;
  logic [31:0] rsp_raddr;
  logic [31:0] rsp_far;
  logic [2:0]  rsp_perm;

  int checks = 0;
  int fails  = 0;
  bit mon_on = 0;

  xlate_verdict u_xlate_verdict (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic exp_t prot_fault(input int kind, input logic [31:0] ea);
    exp_t e;
    e = '0;
    if (kind == 2) begin
      e.ft = 2'd1; e.code = 32'h0800_0000;
    end else begin
      e.ft = 2'd2; e.far = ea;
      e.code = (kind == 1) ? 32'h0A00_0000 : 32'h0800_0000;
    end
    return e;
  endfunction

  function automatic exp_t ref_model(input int kind, input logic [31:0] ea,
      input bit ion, input bit don, input bit usr, input logic [31:0] sg,
      input bit bh, input logic [31:0] br, input logic [2:0] bp,
      input bit pf, input logic [31:0] pr, input int pp, input int cls,
      output string tag);
    exp_t e;
    int need;
    int key;
    int rwtab [8];
    int have;
    e = '0;
    rwtab = '{3, 3, 3, 1, 0, 1, 3, 1};
    need = 1 << kind;
    if (kind == 3) begin
      e.bad = 1; tag = "R10"; return e;
    end
    if ((kind == 2) ? !ion : !don) begin
      e.ok = 1; e.rl = 1; e.raddr = ea; e.perm = 3'b111; tag = "R1"; return e;
    end
    key = usr ? int'(sg[29]) : int'(sg[30]);
    if (bh) begin
      tag = "R2";
      if ((int'(bp) & need) == need) begin
        e.ok = 1; e.raddr = br; e.perm = bp;
      end else e = prot_fault(kind, ea);
      return e;
    end
    if (sg[31]) begin
      if (sg[28:20] == 9'h07F) begin
        tag = "R7"; e.ok = 1; e.perm = 3'b111; e.raddr = {sg[3:0], ea[27:0]};
      end else if (kind == 2) begin
        tag = "R4"; e.ft = 2'd1; e.code = 32'h1000_0000;
      end else begin
        tag = "R8";
        case (cls)
          0: begin
            tag = "R9";
            if ((kind == 0 && key == 0) || (kind == 1 && key == 1)) begin
              e.ok = 1; e.raddr = ea; e.perm = 3'(need);
            end else e = prot_fault(kind, ea);
          end
          1: begin e.ft = 2'd3; e.far = ea; end
          2: begin e.ft = 2'd2; e.far = ea; e.code = kind == 1 ? 32'h0600_0000 : 32'h0400_0000; end
          3: begin e.ok = 1; e.raddr = ea; e.perm = 3'(need); end
          4: begin e.ft = 2'd2; e.far = ea; e.code = kind == 1 ? 32'h0610_0000 : 32'h0410_0000; end
          default: begin tag = "R10"; e.bad = 1; end
        endcase
      end
      return e;
    end
    if (kind == 2 && sg[28]) begin
      tag = "R4"; e.ft = 2'd1; e.code = 32'h1000_0000; return e;
    end
    if (!pf) begin
      tag = "R5";
      if (kind == 2) begin e.ft = 2'd1; e.code = 32'h4000_0000; end
      else begin e.ft = 2'd2; e.far = ea; e.code = kind == 1 ? 32'h4200_0000 : 32'h4000_0000; end
      return e;
    end
    have = rwtab[key * 4 + pp] | (sg[28] ? 0 : 4);
    if ((have & need) == 0) begin
      tag = "R6"; e = prot_fault(kind, ea);
    end else begin
      tag = "R3"; e.ok = 1; e.perm = 3'(have); e.raddr = {pr[31:12], ea[11:0]};
    end
    return e;
  endfunction

  // reference pipeline: one registered stage, like the port timing
  bit    mdl_v;
  exp_t  mdl_e;
  string mdl_tag;

  always @(posedge clk or negedge rst_n) begin
    exp_t  e;
    string t;
    if (!rst_n) begin
      mdl_v <= 0;
    end else begin
      mdl_v <= req_valid;
      if (req_valid) begin
        e = ref_model(int'(req_kind), req_ea, xlat_on_inst, xlat_on_data, user_mode,
                      seg_word, blk_hit, blk_raddr, blk_perm, pg_found, pg_raddr,
                      int'(pg_pp), int'(ds_class), t);
        mdl_e   <= e;
        mdl_tag <= t;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    exp_t got;
    if (mon_on) begin
      got = {rsp_ok, rsp_real, rsp_illegal, rsp_ftype, rsp_code, rsp_raddr, rsp_far, rsp_perm};
      checks++;
      if (rsp_valid !== mdl_v) begin
        fails++;
        $display("FAIL R11 valid pulse: got %0b exp %0b", rsp_valid, mdl_v);
      end else if (mdl_v) begin
        checks++;
        if (got !== mdl_e) begin
          fails++;
          $display("FAIL %s: got ok=%0b real=%0b bad=%0b ft=%0d code=%h ra=%h far=%h perm=%b exp ok=%0b real=%0b bad=%0b ft=%0d code=%h ra=%h far=%h perm=%b",
                   mdl_tag, got.ok, got.rl, got.bad, got.ft, got.code, got.raddr, got.far, got.perm,
                   mdl_e.ok, mdl_e.rl, mdl_e.bad, mdl_e.ft, mdl_e.code, mdl_e.raddr, mdl_e.far, mdl_e.perm);
        end
        checks++;
        if ($countones({rsp_ok, rsp_ftype != 2'd0, rsp_illegal}) != 1) begin
          fails++;
          $display("FAIL R12 outcome count: got %0d exp 1",
                   $countones({rsp_ok, rsp_ftype != 2'd0, rsp_illegal}));
        end
      end
    end
  end

  task automatic set_base();
    req_kind = 2'd0; req_ea = 32'h1234_5678;
    xlat_on_inst = 1; xlat_on_data = 1; user_mode = 0;
    seg_word = 32'h0000_0000; blk_hit = 0; blk_raddr = 32'hA000_0000; blk_perm = 3'b000;
    pg_found = 1; pg_raddr = 32'h0BCD_E000; pg_pp = 2'd2; ds_class = 3'd0;
  endtask

  // one request then one idle cycle; called at a falling edge
  task automatic fire();
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    rst_n = 0; req_valid = 0;
    set_base();
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 0 || rsp_ok !== 0 || rsp_code !== 0) begin
      fails++;
      $display("FAIL R11 reset state: got v=%0b ok=%0b code=%h exp 0 0 0", rsp_valid, rsp_ok, rsp_code);
    end
    rst_n = 1;
    repeat (4) @(negedge clk);
    mon_on = 1;

    // R1 untranslated, both sides
    set_base(); xlat_on_data = 0; fire();
    set_base(); req_kind = 2'd2; xlat_on_inst = 0; seg_word = 32'h9000_0000; fire();
    // R2 block hit: grant, write shortfall, fetch shortfall, priority over direct store
    set_base(); blk_hit = 1; blk_perm = 3'b001; fire();
    set_base(); blk_hit = 1; blk_perm = 3'b001; req_kind = 2'd1; fire();
    set_base(); blk_hit = 1; blk_perm = 3'b011; req_kind = 2'd2; fire();
    set_base(); blk_hit = 1; blk_perm = 3'b111; seg_word = 32'h8000_0000; ds_class = 3'd1; fire();
    // R3 / R6 key table sweep through both key sources
    for (int u = 0; u < 2; u++)
      for (int k = 0; k < 2; k++)
        for (int p = 0; p < 4; p++)
          for (int kd = 0; kd < 3; kd++)
            for (int nx = 0; nx < 2; nx++) begin
              set_base();
              user_mode = u[0];
              seg_word[29] = u[0] ? k[0] : ~k[0];
              seg_word[30] = u[0] ? ~k[0] : k[0];
              seg_word[28] = nx[0];
              pg_pp = p[1:0]; req_kind = kd[1:0];
              fire();
            end
    // R4 no-execute fetch beats a missing entry; direct-store fetch
    set_base(); req_kind = 2'd2; seg_word = 32'h1000_0000; pg_found = 0; fire();
    set_base(); req_kind = 2'd2; seg_word = 32'h8010_0000; fire();
    // R5 missing entry for each kind
    for (int kd = 0; kd < 3; kd++) begin
      set_base(); pg_found = 0; req_kind = kd[1:0]; fire();
    end
    // R7 forced-memory direct store, every kind
    for (int kd = 0; kd < 3; kd++) begin
      set_base(); seg_word = 32'h87F0_0005; req_kind = kd[1:0]; ds_class = 3'd1; fire();
    end
    // R8 / R9 / R10 direct-store classes, reads and writes, both keys
    for (int c = 0; c < 8; c++)
      for (int kd = 0; kd < 2; kd++)
        for (int k = 0; k < 2; k++) begin
          set_base(); seg_word = 32'h8020_0000; seg_word[30] = k[0];
          ds_class = c[2:0]; req_kind = kd[1:0]; fire();
        end
    // R10 illegal kind
    set_base(); req_kind = 2'd3; fire();
    // R11 back-to-back requests, with random traffic
    for (int i = 0; i < 600; i++) begin
      req_kind = 2'($urandom % 4);
      req_ea = $urandom;
      xlat_on_inst = ($urandom % 8) != 0;
      xlat_on_data = ($urandom % 8) != 0;
      user_mode = 1'($urandom);
      seg_word = $urandom;
      if (($urandom % 4) == 0) seg_word[28:20] = 9'h07F;
      blk_hit = ($urandom % 4) == 0;
      blk_raddr = $urandom; blk_perm = 3'($urandom);
      pg_found = ($urandom % 5) != 0;
      pg_raddr = $urandom; pg_pp = 2'($urandom);
      ds_class = 3'($urandom);
      req_valid = ($urandom % 4) != 0;
      @(negedge clk);
    end
    req_valid = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule